// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the condition flags of a small 8-bit microcontroller core. Each cycle it can take an ALU operation class together with the operands and the result. From these it derives the carry, half-carry (nibble carry), zero and signed-overflow flags. The flags are kept in an 8-bit register that software can read back. Software can also write that register.

Two further flags record power management. The power-down flag and the watchdog-expiry flag are out of reach of register writes. They move only on four event strobes:
- power-up
- watchdog time-out
- the watchdog-clear instruction
- the halt instruction

The stored carry is also sent back to the ALU on its own output, for add-with-carry and rotate instructions.

Top module: `status_flag_reg`

## Requirements
- R1: Bit layout of `statusOut`:

  | Bit | Flag |
  |-----|------|
  | 0 | carry |
  | 1 | half-carry |
  | 2 | zero |
  | 3 | overflow |
  | 4 | power-down |
  | 5 | time-out |
  | 7:6 | unused, always read 0 |

  Asynchronous reset (`rst_n` low) clears every bit.
- R2: The `aluOp` encoding is 1 = add and 2 = subtract. On add, carry is set when there is a carry out of bit 7. On subtract (result = A - B - borrow), carry is set when no borrow occurs. In both cases the flag is visible the cycle after the operation.
- R3: On add, half-carry is set when there is a carry out of bit 3. On subtract, it is set when the low nibble does not borrow from the high nibble.
- R4: On add, subtract or logic (`aluOp` = 3), zero is set exactly when `aluRes` is 0.
- R5: On add or subtract, overflow is set when the carry into bit 7 differs from the carry out of bit 7. This is the same as the result leaving the signed 8-bit range.
- R6: A register write (`regWrEn`) loads `regWrData` bits 0..3 into carry, half-carry, zero and overflow. Power-down and time-out keep their values.
- R7: When a write and an ALU operation fall in the same cycle, the ALU value wins for each flag that the operation updates. The remaining flags take the write data.
- R8: A logic operation updates only zero. `aluOp` values 0, 6 and 7 update no flag.
- R9: Rotate-left-through-carry (`aluOp` = 4) loads carry from `opA` bit 7. Rotate-right-through-carry (`aluOp` = 5) loads carry from `opA` bit 0. Both leave the other flags unchanged.
- R10: Power-down is set by halt and cleared by power-up or watchdog-clear. A clear wins over halt in the same cycle.
- R11: Time-out is set by watchdog time-out and cleared by power-up, watchdog-clear or halt. A time-out wins over every clear in the same cycle.
- R12: `carryOut` always equals status bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aluOp | input | 3 | Operation class: 0 none, 1 add, 2 sub, 3 logic, 4 rotate-left-through-carry, 5 rotate-right-through-carry |
| opA | input | 8 | First ALU operand |
| opB | input | 8 | Second ALU operand (subtrahend on subtract) |
| aluRes | input | 8 | ALU result for this operation |
| regWrEn | input | 1 | Software write strobe |
| regWrData | input | 8 | Software write data |
| evPowerUp | input | 1 | Power-up event strobe |
| evWdtTimeout | input | 1 | Watchdog expiry strobe |
| evClrWdt | input | 1 | Watchdog-clear instruction strobe |
| evHalt | input | 1 | Halt instruction strobe |
| statusOut | output | 8 | Status register value |
| carryOut | output | 1 | Stored carry for the ALU |

## Verification
The assertions assume that `aluRes` is consistent with `opA`, `opB` and the operation class. For add this means A + B + carry-in. For subtract it means A - B - borrow. The block derives its carry chain from all three values, so an inconsistent result would make the carry flags meaningless. The stimulus therefore builds every arithmetic result from the drawn operands and a random carry-in or borrow. Results for logic operations are drawn freely, because only zero is taken from them. Event strobes are rare and may coincide, so the priority cases are reached both in the directed section and in the random section.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_C  = 0;
  localparam int BIT_AC = 1;
  localparam int BIT_Z  = 2;
  localparam int BIT_OV = 3;
  localparam int BIT_PD = 4;
  localparam int BIT_TO = 5;
  localparam int USED_W = 6;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_LOGIC = 3'd3,
    OP_RLC   = 3'd4,
    OP_RRC   = 3'd5
  } aluOp_e;

  typedef struct packed {
    logic ldArith;
    logic subSel;
    logic ldZero;
    logic ldRotL;
    logic ldRotR;
    logic swWrite;
    logic pdSet;
    logic pdClr;
    logic toSet;
    logic toClr;
  } sfrStrobe_t;
endpackage

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
(
  input  logic [2:0] aluOp,
  input  logic       regWrEn,
  input  logic       evPowerUp,
  input  logic       evWdtTimeout,
  input  logic       evClrWdt,
  input  logic       evHalt,
  output sfrStrobe_t strobe
);
  logic pdClear;
  logic toClear;

  assign pdClear = evPowerUp | evClrWdt;
  assign toClear = evPowerUp | evClrWdt | evHalt;

  always_comb begin
    strobe         = '0;
    strobe.ldArith = (aluOp == OP_ADD) || (aluOp == OP_SUB);
    strobe.subSel  = (aluOp == OP_SUB);
    strobe.ldZero  = strobe.ldArith || (aluOp == OP_LOGIC);
    strobe.ldRotL  = (aluOp == OP_RLC);
    strobe.ldRotR  = (aluOp == OP_RRC);
    strobe.swWrite = regWrEn;
    // power-down: clear sources beat halt
    strobe.pdClr   = pdClear;
    strobe.pdSet   = evHalt & ~pdClear;
    // time-out: expiry beats every clear source
    strobe.toSet   = evWdtTimeout;
    strobe.toClr   = toClear & ~evWdtTimeout;
  end
endmodule

// File: rtl/sfr_flag_calc.sv
module sfr_flag_calc #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluRes,
  input  logic              subSel,
  output logic              carryNew,
  output logic              halfNew,
  output logic              zeroNew,
  output logic              ovfNew,
  output logic              rotLBit,
  output logic              rotRBit
);
  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] addendB;
  logic [DATA_W-1:0] carryInto;
  logic              carryOutTop;

  // subtraction is treated as A + ~B + !borrow
  assign addendB     = subSel ? ~opB : opB;
  assign carryInto   = opA ^ addendB ^ aluRes;
  assign carryOutTop = (opA[MSB] & addendB[MSB]) |
                       ((opA[MSB] ^ addendB[MSB]) & carryInto[MSB]);

  assign carryNew = carryOutTop;
  assign halfNew  = carryInto[HALF];
  assign zeroNew  = (aluRes == '0);
  assign ovfNew   = carryOutTop ^ carryInto[MSB];
  assign rotLBit  = opA[MSB];
  assign rotRBit  = opA[0];
endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath
  import sfr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sfrStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluRes,
  input  logic [3:0]        wrFlags,
  output logic [STAT_W-1:0] statusOut
);
  logic carryNew, halfNew, zeroNew, ovfNew, rotLBit, rotRBit;
  logic flagC, flagAc, flagZ, flagOv, flagPd, flagTo;
  logic nextC, nextAc, nextZ, nextOv, nextPd, nextTo;

  sfr_flag_calc #(.DATA_W(DATA_W)) i_calc (
    .opA      (opA),
    .opB      (opB),
    .aluRes   (aluRes),
    .subSel   (strobe.subSel),
    .carryNew (carryNew),
    .halfNew  (halfNew),
    .zeroNew  (zeroNew),
    .ovfNew   (ovfNew),
    .rotLBit  (rotLBit),
    .rotRBit  (rotRBit)
  );

  always_comb begin
    nextC  = strobe.swWrite ? wrFlags[BIT_C]  : flagC;
    nextAc = strobe.swWrite ? wrFlags[BIT_AC] : flagAc;
    nextZ  = strobe.swWrite ? wrFlags[BIT_Z]  : flagZ;
    nextOv = strobe.swWrite ? wrFlags[BIT_OV] : flagOv;
    if (strobe.ldArith) begin
      nextC  = carryNew;
      nextAc = halfNew;
      nextOv = ovfNew;
    end
    if (strobe.ldZero) nextZ = zeroNew;
    if (strobe.ldRotL) nextC = rotLBit;
    if (strobe.ldRotR) nextC = rotRBit;

    nextPd = flagPd;
    if (strobe.pdClr)      nextPd = 1'b0;
    else if (strobe.pdSet) nextPd = 1'b1;

    nextTo = flagTo;
    if (strobe.toSet)      nextTo = 1'b1;
    else if (strobe.toClr) nextTo = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagC  <= 1'b0;
      flagAc <= 1'b0;
      flagZ  <= 1'b0;
      flagOv <= 1'b0;
      flagPd <= 1'b0;
      flagTo <= 1'b0;
    end else begin
      flagC  <= nextC;
      flagAc <= nextAc;
      flagZ  <= nextZ;
      flagOv <= nextOv;
      flagPd <= nextPd;
      flagTo <= nextTo;
    end
  end

  always_comb begin
    statusOut         = '0;
    statusOut[BIT_C]  = flagC;
    statusOut[BIT_AC] = flagAc;
    statusOut[BIT_Z]  = flagZ;
    statusOut[BIT_OV] = flagOv;
    statusOut[BIT_PD] = flagPd;
    statusOut[BIT_TO] = flagTo;
  end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sfr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        aluOp,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluRes,
  input  logic              regWrEn,
  input  logic [STAT_W-1:0] regWrData,
  input  logic              evPowerUp,
  input  logic              evWdtTimeout,
  input  logic              evClrWdt,
  input  logic              evHalt,
  output logic [STAT_W-1:0] statusOut,
  output logic              carryOut
);
  sfrStrobe_t strobe;
  logic       unusedWrBits;

  assign unusedWrBits = ^regWrData[STAT_W-1:4];

  sfr_ctrl i_ctrl (
    .aluOp        (aluOp),
    .regWrEn      (regWrEn),
    .evPowerUp    (evPowerUp),
    .evWdtTimeout (evWdtTimeout),
    .evClrWdt     (evClrWdt),
    .evHalt       (evHalt),
    .strobe       (strobe)
  );

  sfr_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .aluRes    (aluRes),
    .wrFlags   (regWrData[3:0]),
    .statusOut (statusOut)
  );

  assign carryOut = statusOut[BIT_C];
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        aluOp,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] aluRes,
  input logic              regWrEn,
  input logic              evPowerUp,
  input logic              evWdtTimeout,
  input logic              evClrWdt,
  input logic              evHalt,
  input logic [7:0]        statusOut,
  input logic              carryOut
);
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    statusOut[7:6] == 2'b00);

  a_r4_zero_follows_result: assert property (@(posedge clk) disable iff (!rst_n)
    (aluOp == 3'd1 || aluOp == 3'd2 || aluOp == 3'd3)
    |=> statusOut[2] == ($past(aluRes) == '0));

  a_r6_write_keeps_power_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !evPowerUp && !evWdtTimeout && !evClrWdt && !evHalt)
    |=> $stable(statusOut[5:4]));

  a_r8_logic_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
    (aluOp == 3'd3 && !regWrEn) |=> ($stable(statusOut[1:0]) && $stable(statusOut[3])));

  a_r9_rotate_left_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (aluOp == 3'd4 && !regWrEn) |=> (statusOut[0] == $past(opA[DATA_W-1]) && $stable(statusOut[3:1])));

  a_r10_halt_sets_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (evHalt && !evPowerUp && !evClrWdt) |=> statusOut[4]);

  a_r11_timeout_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
    evWdtTimeout |=> statusOut[5]);

  a_r12_carry_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    carryOut == statusOut[0]);
endmodule

bind status_flag_reg status_flag_reg_chk #(.DATA_W(DATA_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .aluOp        (aluOp),
  .opA          (opA),
  .aluRes       (aluRes),
  .regWrEn      (regWrEn),
  .evPowerUp    (evPowerUp),
  .evWdtTimeout (evWdtTimeout),
  .evClrWdt     (evClrWdt),
  .evHalt       (evHalt),
  .statusOut    (statusOut),
  .carryOut     (carryOut)
);

// File: tb/test_status_flag_reg.sv
`timescale 1ns/1ps
module test_status_flag_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] aluOp = '0;
  logic [7:0] opA = '0, opB = '0, aluRes = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       evPowerUp = 1'b0, evWdtTimeout = 1'b0, evClrWdt = 1'b0, evHalt = 1'b0;
  logic [7:0] statusOut;
  logic       carryOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state: expected flags after the most recent edge
  int mC = 0, mAc = 0, mZ = 0, mOv = 0, mPd = 0, mTo = 0;
  string phase = "reset";

  always #10 clk = ~clk;

  status_flag_reg i_status_flag_reg (
    .clk(clk), .rst_n(rst_n), .aluOp(aluOp), .opA(opA), .opB(opB), .aluRes(aluRes),
    .regWrEn(regWrEn), .regWrData(regWrData), .evPowerUp(evPowerUp),
    .evWdtTimeout(evWdtTimeout), .evClrWdt(evClrWdt), .evHalt(evHalt),
    .statusOut(statusOut), .carryOut(carryOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 carry", statusOut[0], mC);
    chk("R3 half-carry", statusOut[1], mAc);
    chk("R4 zero", statusOut[2], mZ);
    chk("R5 overflow", statusOut[3], mOv);
    chk("R10 power-down", statusOut[4], mPd);
    chk("R11 time-out", statusOut[5], mTo);
    chk("R1 unused bits", statusOut[7:6], 0);
    chk("R12 carryOut", carryOut, mC);
  endtask

  // behavioural next-state of the reference model for the inputs now driven
  task automatic modelStep(input int cin);
    int a, b, r, sa, sb, sr;
    a = opA; b = opB; r = aluRes;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (regWrEn) begin
      mC = regWrData[0]; mAc = regWrData[1]; mZ = regWrData[2]; mOv = regWrData[3];
    end
    case (aluOp)
      3'd1: begin
        mC  = (a + b + cin > 255) ? 1 : 0;
        mAc = ((a % 16) + (b % 16) + cin > 15) ? 1 : 0;
        sr  = sa + sb + cin;
        mOv = (sr > 127 || sr < -128) ? 1 : 0;
        mZ  = (r == 0) ? 1 : 0;
      end
      3'd2: begin
        mC  = (a - b - cin >= 0) ? 1 : 0;
        mAc = ((a % 16) - (b % 16) - cin >= 0) ? 1 : 0;
        sr  = sa - sb - cin;
        mOv = (sr > 127 || sr < -128) ? 1 : 0;
        mZ  = (r == 0) ? 1 : 0;
      end
      3'd3: mZ = (r == 0) ? 1 : 0;
      3'd4: mC = a / 128;
      3'd5: mC = a % 2;
      default: ;
    endcase
    if (evPowerUp || evClrWdt) mPd = 0;
    else if (evHalt) mPd = 1;
    if (evWdtTimeout) mTo = 1;
    else if (evPowerUp || evClrWdt || evHalt) mTo = 0;
  endtask

  // drive one cycle of stimulus at a falling edge, then check after the next rising edge
  task automatic cycle(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input int cin, input logic [7:0] logicRes, input logic wr,
                       input logic [7:0] wd, input logic pu, input logic wdt,
                       input logic cw, input logic hl);
    int rr;
    aluOp = op; opA = a; opB = b;
    if (op == 3'd1) rr = (a + b + cin) & 255;
    else if (op == 3'd2) rr = (a - b - cin) & 255;
    else rr = logicRes;
    aluRes = rr[7:0];
    regWrEn = wr; regWrData = wd;
    evPowerUp = pu; evWdtTimeout = wdt; evClrWdt = cw; evHalt = hl;
    modelStep(cin);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1 reset";
    compareAll();
    rst_n = 1'b1;
    @(negedge clk);
    idle();

    phase = "R2 R3 R5 add 0x7F+0x01"; // half carry, overflow, no carry
    cycle(3'd1, 8'h7F, 8'h01, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R2 R4 add 0xFF+0x01 zero with carry";
    cycle(3'd1, 8'hFF, 8'h01, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R2 add with carry-in";
    cycle(3'd1, 8'h80, 8'h7F, 1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R2 R3 sub no borrow";
    cycle(3'd2, 8'h25, 8'h13, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R2 R3 sub with borrow";
    cycle(3'd2, 8'h10, 8'h21, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R5 sub signed overflow";
    cycle(3'd2, 8'h80, 8'h01, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R8 logic only zero";
    cycle(3'd3, 8'h55, 8'hAA, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle(3'd3, 8'h55, 8'hAA, 0, 8'h40, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R9 rotate left carry";
    cycle(3'd4, 8'h80, 8'h00, 0, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R9 rotate right carry";
    cycle(3'd5, 8'hFE, 8'h00, 0, 8'h7F, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R10 halt sets pd, clears to";
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    phase = "R11 timeout sets to";
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    phase = "R6 write ignores pd/to";
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b1, 8'hC5, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R7 write with logic op";
    cycle(3'd3, 8'h00, 8'h00, 0, 8'h12, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R7 write with add";
    cycle(3'd1, 8'h01, 8'h01, 0, 8'h00, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R7 write with rotate";
    cycle(3'd5, 8'h01, 8'h00, 0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R8 unused op codes";
    cycle(3'd6, 8'hFF, 8'hFF, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle(3'd7, 8'h00, 8'h00, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R10 clrwdt beats halt";
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    phase = "R11 timeout beats halt and clrwdt";
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    phase = "R10 R11 power-up clears";
    cycle(3'd0, 8'h00, 8'h00, 0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);

    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic [7:0] ra, rb, rl, rw;
      int cin, ev;
      op = 3'($urandom_range(0, 7));
      ra = 8'($urandom); rb = 8'($urandom); rl = 8'($urandom);
      if ($urandom_range(0, 3) == 0) rl = 8'h00;
      rw = 8'($urandom);
      cin = int'($urandom_range(0, 1));
      ev = int'($urandom_range(0, 15));
      cycle(op, ra, rb, cin, rl, 1'($urandom_range(0, 3) == 0), rw,
            1'(ev == 0), 1'(ev == 1 || ev == 4), 1'(ev == 2 || ev == 4 || ev == 5),
            1'(ev == 3 || ev == 5));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule